// File: doc/BRIEF.md
# Debug Exception Enable Router

This block decides, every cycle, whether a processor core may raise debug exceptions at its present privilege level, and to which privilege level (0 to 3) such an exception is delivered. It takes the current level, the security state, the register width (64-bit or 32-bit) of each level, the hypervisor routing bits, the monitor and system debug control fields, the debug mask bit and the double-lock bit. It returns a generate-enable flag, the destination level, a single-step-active flag and the "same level" bit that goes into the exception syndrome.

The only state is a software lock, held in a two-state machine with states `LK_HELD` (locked) and `LK_OPEN` (unlocked). Reset enters `LK_HELD`. While the write strobe is high, the transition is set by the write: a 64-bit-style write goes to `LK_HELD` when bit 0 is one and to `LK_OPEN` otherwise. A 32-bit-style write goes to `LK_HELD` only when the data equals the key 0xC5ACCE55, and to `LK_OPEN` for any other value. With no strobe the state holds. All other outputs are combinational from the inputs and this state.

Top module: `dbg_exc_router`

## Requirements
- R1: When `el2_en` is 1 and either `hyp_tge` or `hyp_tde` is 1, `tgt_el` is 2.
- R2: Otherwise `tgt_el` is 3 when `el3_present` is 1, `el_aa64[3]` is 0 and `secure` is 1. In every other case it is 1.
- R3: When `cur_el` is 3 and that level is 64-bit (`el_aa64[3]`=1), `gen_en` is 0.
- R4: On the 64-bit path, `gen_en` is 0 when `secure` is 1 and `mon_sdd` is 1, at every level below 3.
- R5: On the 64-bit path, when `tgt_el` equals `cur_el`, `gen_en` is `sys_kde & ~dmask`. Otherwise `gen_en` is 1 exactly when `tgt_el` is greater than `cur_el`.
- R6: `gen_en` is 0 whenever the lock is held or `dlock` is 1. After reset the lock is held and `lk_status` reads 4'b1010: bit 1 is the lock, bit 3 is a constant 1, and the other bits are 0. When unlocked, `lk_status` reads 4'b1000.
- R7: The 32-bit path applies when `el_aa64[cur_el]` is 0. At level 0 with `el_aa64[1]`=1 it uses the 64-bit rules instead. In secure state at level 0, `suser_dbg`=1 enables generation. Otherwise, in secure state, `mon_spd` = 2'b10 disables generation and the other three codes enable it. In non-secure state, generation is enabled unless `cur_el` is 2.
- R8: `ss_active` is 1 exactly when `sys_ss` is 1, `el_aa64[tgt_el]` is 1 and `gen_en` is 1.
- R9: `same_el` is 1 exactly when `tgt_el` equals `cur_el`.
- R10: A strobed write with `lk_wr_aa64`=1 sets the lock to `lk_wdata[0]`. A strobed write with `lk_wr_aa64`=0 sets the lock only when `lk_wdata` is 0xC5ACCE55 and clears it otherwise. The new value shows at `lk_status` after the clock edge. With `lk_wr` at 0, the lock is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cur_el | input | 2 | Current privilege level |
| secure | input | 1 | Core is in secure state |
| el_aa64 | input | 4 | Bit n is 1 when level n runs 64-bit |
| el2_en | input | 1 | Level 2 is enabled |
| el3_present | input | 1 | Level 3 is implemented |
| hyp_tge | input | 1 | Hypervisor trap-general-exceptions bit |
| hyp_tde | input | 1 | Hypervisor trap-debug-exceptions bit |
| mon_sdd | input | 1 | Secure debug disable |
| mon_spd | input | 2 | Secure privileged debug field |
| sys_kde | input | 1 | Same-level (kernel) debug enable |
| sys_ss | input | 1 | Software single-step enable |
| dmask | input | 1 | Debug exception mask |
| suser_dbg | input | 1 | Secure user invasive debug enable |
| dlock | input | 1 | Double lock |
| lk_wr | input | 1 | Lock write strobe, one cycle |
| lk_wr_aa64 | input | 1 | Write uses 64-bit semantics |
| lk_wdata | input | 32 | Lock write data |
| gen_en | output | 1 | Debug exceptions may be generated |
| tgt_el | output | 2 | Destination level for debug exceptions |
| ss_active | output | 1 | Single-step is active |
| same_el | output | 1 | Syndrome "same level" bit |
| lk_status | output | 4 | Lock status word |

## Verification
The only internal state is the lock. If that state is wrong, `lk_status` bit 1 shows it one clock edge after the write that caused it. From the same moment `gen_en` and `ss_active` are stuck low, or are enabled when they should not be, for every level and security combination. The bench therefore reads the status right after every lock write. It then sweeps levels, security, widths and routing in both lock states, so a bad transition or bad reset value shows up on the first following vector. Routing and enable errors are purely combinational and show up in the cycle of the vector that triggers them.

// File: rtl/dbg_route_pkg.sv
package dbg_route_pkg;
    typedef enum logic [1:0] {
        PL0 = 2'd0,
        PL1 = 2'd1,
        PL2 = 2'd2,
        PL3 = 2'd3
    } plevel_t;

    typedef enum logic {
        LK_OPEN = 1'b0,
        LK_HELD = 1'b1
    } lock_state_t;

    localparam logic [1:0] SPD_OFF = 2'b10;
    localparam int         NUM_PL  = 4;
    localparam int         STAT_W  = 4;
endpackage

// File: rtl/dbg_target_sel.sv
module dbg_target_sel
    import dbg_route_pkg::*;
(
    input  logic    el2_en,
    input  logic    el3_present,
    input  logic    el3_aa64,
    input  logic    secure,
    input  logic    hyp_tge,
    input  logic    hyp_tde,
    output plevel_t tgt
);
    always_comb begin
        if (el2_en && (hyp_tge || hyp_tde))
            tgt = PL2;
        else if (el3_present && !el3_aa64 && secure)
            tgt = PL3;
        else
            tgt = PL1;
    end
endmodule

// File: rtl/dbg_gen_policy.sv
module dbg_gen_policy
    import dbg_route_pkg::*;
(
    input  plevel_t           cur,
    input  plevel_t           tgt,
    input  logic              secure,
    input  logic [NUM_PL-1:0] el_aa64,
    input  logic              mon_sdd,
    input  logic [1:0]        mon_spd,
    input  logic              sys_kde,
    input  logic              dmask,
    input  logic              suser_dbg,
    input  logic              locked,
    input  logic              dlock,
    output logic              gen_en
);
    logic wide_ok;
    logic narrow_ok;

    // 64-bit rule set
    always_comb begin
        if (cur == PL3)
            wide_ok = 1'b0;
        else if (secure && mon_sdd)
            wide_ok = 1'b0;
        else if (cur == tgt)
            wide_ok = sys_kde && !dmask;
        else
            wide_ok = (tgt > cur);
    end

    // 32-bit rule set
    always_comb begin
        if (cur == PL0 && el_aa64[1])
            narrow_ok = wide_ok;
        else if (secure) begin
            if (cur == PL0 && suser_dbg)
                narrow_ok = 1'b1;
            else
                narrow_ok = (mon_spd != SPD_OFF);
        end else
            narrow_ok = (cur != PL2);
    end

    assign gen_en = !locked && !dlock && (el_aa64[cur] ? wide_ok : narrow_ok);
endmodule

// File: rtl/dbg_lock_fsm.sv
module dbg_lock_fsm
    import dbg_route_pkg::*;
#(
    parameter int          KEY_W    = 32,
    parameter logic [31:0] LOCK_KEY = 32'hC5AC_CE55
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              wr_aa64,
    input  logic [KEY_W-1:0]  wdata,
    output logic              locked,
    output logic [STAT_W-1:0] status
);
    localparam logic [KEY_W-1:0] KEY_VAL = LOCK_KEY[KEY_W-1:0];

    lock_state_t state, state_nx;
    logic        want_lock;

    assign want_lock = wr_aa64 ? wdata[0] : (wdata == KEY_VAL);

    always_comb begin
        state_nx = state;
        unique case (state)
            LK_HELD: if (wr && !want_lock) state_nx = LK_OPEN;
            LK_OPEN: if (wr && want_lock)  state_nx = LK_HELD;
            default: state_nx = LK_HELD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= LK_HELD;
        else        state <= state_nx;
    end

    always_comb begin
        unique case (state)
            LK_HELD: begin locked = 1'b1; status = 4'b1010; end
            LK_OPEN: begin locked = 1'b0; status = 4'b1000; end
            default: begin locked = 1'b1; status = 4'b1010; end
        endcase
    end

    // R10: 64-bit write loads bit 0
    p_wide_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && wr_aa64) |=> (locked == $past(wdata[0])));
    // R10: 32-bit write locks only on the key
    p_key_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !wr_aa64) |=> (locked == $past(wdata == KEY_VAL)));
    // R10: no strobe, no change
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(locked));
endmodule

// File: rtl/dbg_exc_router.sv
module dbg_exc_router
    import dbg_route_pkg::*;
#(
    parameter int          KEY_W    = 32,
    parameter logic [31:0] LOCK_KEY = 32'hC5AC_CE55
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cur_el,
    input  logic              secure,
    input  logic [NUM_PL-1:0] el_aa64,
    input  logic              el2_en,
    input  logic              el3_present,
    input  logic              hyp_tge,
    input  logic              hyp_tde,
    input  logic              mon_sdd,
    input  logic [1:0]        mon_spd,
    input  logic              sys_kde,
    input  logic              sys_ss,
    input  logic              dmask,
    input  logic              suser_dbg,
    input  logic              dlock,
    input  logic              lk_wr,
    input  logic              lk_wr_aa64,
    input  logic [KEY_W-1:0]  lk_wdata,
    output logic              gen_en,
    output logic [1:0]        tgt_el,
    output logic              ss_active,
    output logic              same_el,
    output logic [STAT_W-1:0] lk_status
);
    plevel_t cur;
    plevel_t tgt;
    logic    locked;

    assign cur = plevel_t'(cur_el);

    dbg_target_sel u_tsel (
        .el2_en      (el2_en),
        .el3_present (el3_present),
        .el3_aa64    (el_aa64[3]),
        .secure      (secure),
        .hyp_tge     (hyp_tge),
        .hyp_tde     (hyp_tde),
        .tgt         (tgt)
    );

    dbg_lock_fsm #(.KEY_W(KEY_W), .LOCK_KEY(LOCK_KEY)) u_lock (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (lk_wr),
        .wr_aa64 (lk_wr_aa64),
        .wdata   (lk_wdata),
        .locked  (locked),
        .status  (lk_status)
    );

    dbg_gen_policy u_pol (
        .cur       (cur),
        .tgt       (tgt),
        .secure    (secure),
        .el_aa64   (el_aa64),
        .mon_sdd   (mon_sdd),
        .mon_spd   (mon_spd),
        .sys_kde   (sys_kde),
        .dmask     (dmask),
        .suser_dbg (suser_dbg),
        .locked    (locked),
        .dlock     (dlock),
        .gen_en    (gen_en)
    );

    assign tgt_el    = tgt;
    assign same_el   = (tgt == cur);
    assign ss_active = sys_ss && el_aa64[tgt] && gen_en;

    // R1: hypervisor routing wins
    p_route_hyp_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (el2_en && (hyp_tge || hyp_tde)) |-> (tgt_el == 2'd2));
    // R3: top level in 64-bit never generates
    p_top_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_el == 2'd3 && el_aa64[3]) |-> !gen_en);
    // R6: lock or double lock forces off
    p_lock_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_status[1] || dlock) |-> !gen_en);
    // R8: single-step needs generation and a 64-bit destination
    p_ss_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ss_active |-> (gen_en && sys_ss && el_aa64[tgt_el]));
endmodule

// File: tb/dbg_exc_router_bench.sv
`timescale 1ns/1ps
module dbg_exc_router_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cur_el = 2'd0;
    logic        secure = 1'b0;
    logic [3:0]  el_aa64 = 4'hF;
    logic        el2_en = 1'b0, el3_present = 1'b0, hyp_tge = 1'b0, hyp_tde = 1'b0;
    logic        mon_sdd = 1'b0;
    logic [1:0]  mon_spd = 2'b00;
    logic        sys_kde = 1'b0, sys_ss = 1'b0, dmask = 1'b0, suser_dbg = 1'b0, dlock = 1'b0;
    logic        lk_wr = 1'b0, lk_wr_aa64 = 1'b0;
    logic [31:0] lk_wdata = 32'd0;
    logic        gen_en, ss_active, same_el;
    logic [1:0]  tgt_el;
    logic [3:0]  lk_status;

    int  nvec = 0;
    int  nfail = 0;
    bit  done = 1'b0;
    logic m_locked = 1'b1;

    typedef struct packed {
        logic       gen;
        logic [1:0] tgt;
        logic       ss;
        logic       same;
        logic [3:0] stat;
    } exp_t;
    exp_t q[$];

    always #4 clk = ~clk;

    dbg_exc_router u_dbg_exc_router (
        .clk(clk), .rst_n(rst_n), .cur_el(cur_el), .secure(secure), .el_aa64(el_aa64),
        .el2_en(el2_en), .el3_present(el3_present), .hyp_tge(hyp_tge), .hyp_tde(hyp_tde),
        .mon_sdd(mon_sdd), .mon_spd(mon_spd), .sys_kde(sys_kde), .sys_ss(sys_ss),
        .dmask(dmask), .suser_dbg(suser_dbg), .dlock(dlock), .lk_wr(lk_wr),
        .lk_wr_aa64(lk_wr_aa64), .lk_wdata(lk_wdata), .gen_en(gen_en), .tgt_el(tgt_el),
        .ss_active(ss_active), .same_el(same_el), .lk_status(lk_status)
    );

    function automatic exp_t model();
        exp_t e;
        int   t, c;
        logic g64, g32, g;
        c = int'(cur_el);
        // R1, R2: destination
        if (el2_en && (hyp_tge || hyp_tde)) t = 2;
        else if (el3_present && !el_aa64[3] && secure) t = 3;
        else t = 1;
        // R3, R4, R5: 64-bit rules
        if (c == 3) g64 = 1'b0;
        else if (secure && mon_sdd) g64 = 1'b0;
        else if (c == t) g64 = sys_kde && !dmask;
        else g64 = (t > c);
        // R7: 32-bit rules
        if (c == 0 && el_aa64[1]) g32 = g64;
        else if (secure) g32 = (c == 0 && suser_dbg) ? 1'b1 : (mon_spd != 2'b10);
        else g32 = (c != 2);
        // R6: lock gating
        g = el_aa64[c] ? g64 : g32;
        if (m_locked || dlock) g = 1'b0;
        e.gen  = g;
        e.tgt  = t[1:0];
        e.ss   = sys_ss && el_aa64[t] && g;   // R8
        e.same = (t == c);                    // R9
        e.stat = m_locked ? 4'b1010 : 4'b1000; // R6, R10
        return e;
    endfunction

    // driver: apply inputs already set, push expectation
    task automatic push_vec();
        q.push_back(model());
    endtask

    task automatic lock_write(input logic aa64, input logic [31:0] d);
        @(negedge clk);
        lk_wr = 1'b1; lk_wr_aa64 = aa64; lk_wdata = d;
        @(negedge clk);
        lk_wr = 1'b0;
        m_locked = aa64 ? d[0] : (d == 32'hC5ACCE55);
        push_vec(); // R10 status after the edge
    endtask

    // monitor
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (q.size() > 0) begin
                exp_t e;
                bit   bad;
                e = q.pop_front();
                bad = 1'b0;
                nvec++;
                if (gen_en !== e.gen) begin
                    bad = 1'b1;
                    $display("FAIL R3,R4,R5,R6,R7 gen_en el=%0d sec=%0d: actual %0b expected %0b", cur_el, secure, gen_en, e.gen);
                end
                if (tgt_el !== e.tgt) begin
                    bad = 1'b1;
                    $display("FAIL R1/R2 tgt_el: actual %0d expected %0d", tgt_el, e.tgt);
                end
                if (ss_active !== e.ss) begin
                    bad = 1'b1;
                    $display("FAIL R8 ss_active: actual %0b expected %0b", ss_active, e.ss);
                end
                if (same_el !== e.same) begin
                    bad = 1'b1;
                    $display("FAIL R9 same_el: actual %0b expected %0b", same_el, e.same);
                end
                if (lk_status !== e.stat) begin
                    bad = 1'b1;
                    $display("FAIL R6/R10 lk_status: actual %b expected %b", lk_status, e.stat);
                end
                if (bad) nfail++;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL R1 watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    initial begin
        logic [15:0] mix;
        int n;
        n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R6: reset state locked, generation off even where allowed
        @(negedge clk);
        cur_el = 2'd0; sys_ss = 1'b1; push_vec();
        // R10: strobe low with key present changes nothing
        @(negedge clk);
        lk_wdata = 32'hC5ACCE55; lk_wr_aa64 = 1'b1; push_vec();
        // R10: 32-bit non-key unlocks, key locks, 64-bit bit0
        lock_write(1'b0, 32'hC5ACCE54);
        lock_write(1'b0, 32'hC5ACCE55);
        lock_write(1'b1, 32'h0000_0002);
        lock_write(1'b1, 32'h0000_0001);
        lock_write(1'b1, 32'hFFFF_FFFE);
        // R8: 64-bit EL0 single-step active when open
        @(negedge clk);
        cur_el = 2'd0; el_aa64 = 4'hF; sys_ss = 1'b1; push_vec();
        // R6: double lock kills it
        @(negedge clk);
        dlock = 1'b1; push_vec();
        @(negedge clk);
        dlock = 1'b0; push_vec();
        // exhaustive sweep, R1..R9
        for (int pass = 0; pass < 2; pass++) begin
            if (pass == 1) lock_write(1'b0, 32'hC5ACCE55);
            for (int e = 0; e < 4; e++)
            for (int s = 0; s < 2; s++)
            for (int w = 0; w < 16; w++)
            for (int h = 0; h < 2; h++)
            for (int p3 = 0; p3 < 2; p3++)
            for (int tr = 0; tr < 3; tr++)
            for (int k = 0; k < 2; k++)
            for (int dm = 0; dm < 2; dm++) begin
                if (pass == 1 && (w % 4) != 1) continue;
                n++;
                mix = 16'(n * 37) ^ 16'(n >> 3);
                @(negedge clk);
                cur_el = 2'(e); secure = s[0]; el_aa64 = 4'(w);
                el2_en = h[0]; el3_present = p3[0];
                hyp_tge = (tr == 1); hyp_tde = (tr == 2);
                sys_kde = k[0]; dmask = dm[0];
                mon_spd = mix[1:0]; mon_sdd = mix[2] & mix[5];
                suser_dbg = mix[3]; sys_ss = mix[4] | mix[6];
                dlock = (mix[9:7] == 3'b000);
                push_vec();
            end
        end
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule